// File: doc/BRIEF.md
# Serial Character Receiver with Control and Status Register

This block recovers 8-bit characters from an asynchronous serial line and hands them to a processor through two byte-wide registers. A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. An external tick, running at sixteen times the bit rate, paces the line sampling. The start bit is confirmed at its midpoint, and every later bit is sampled at its own midpoint.

Software uses one control/status register to turn reception on, to choose whether a parity bit is present, and to choose the parity sense. The same register reports a buffer-full flag and three error flags. The error flags are sticky: hardware sets them and only a software write of 0 clears them. The buffer-full flag cannot be written. Reading the received character clears it, and so does turning reception on. A character that completes while the previous one is still unread is thrown away, and the overrun flag is raised.

Top module: `uart_rx_csr`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x00 and the data register (address 1) reads 0x00.
- R2: With enable (bit 0) set, a well-formed frame is assembled least significant bit first into the data register, and buffer-full (bit 1) becomes 1.
- R3: A read of address 1 with the read strobe clears buffer-full on the next clock edge.
- R4: With parity on (bit 5 = 1), a parity bit follows the data. Bit 6 = 1 requires an even count of ones over data and parity, and bit 6 = 0 requires an odd count. A mismatch sets the parity error flag (bit 4), and the character is still stored.
- R5: With parity off (bit 5 = 0), the stop bit directly follows the eighth data bit, and the parity error flag is never set.
- R6: A stop bit sampled as 0 sets the framing error flag (bit 2), and the character is still stored.
- R7: A character that completes while buffer-full is 1 sets the overrun flag (bit 3), and the data register keeps the older character.
- R8: The error flags (bits 4, 3 and 2) stay at 1 until a write to address 0 carries 0 in that bit. Writing 1 to them leaves them unchanged.
- R9: Writes to address 0 cannot change buffer-full directly. A write that moves enable from 0 to 1 forces buffer-full to 0.
- R10: While enable is 0, activity on the serial line changes neither register.
- R11: A low pulse on the line that is no longer low at the middle of the start bit is treated as noise. No character is produced, and a proper frame that follows is received correctly.
- R12: Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| busAddr | input | 1 | Register select: 0 control/status, 1 received data |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (a read of address 1 clears buffer-full) |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data, combinational from busAddr |

## Verification
A received character and its flags are registered on the clock edge that follows the stop-bit midpoint tick, half a bit before the frame ends. The bench therefore reads the registers only after the whole stop bit and an idle gap have passed. A register write or a clearing read takes effect on the next rising edge. Every read is sampled one nanosecond after a falling edge, so the value seen always reflects the edges that came before it and never the one about to happen.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int REG_W = 8;

  localparam int CSR_RXEN   = 0;
  localparam int CSR_FULL   = 1;
  localparam int CSR_FRMERR = 2;
  localparam int CSR_OVRERR = 3;
  localparam int CSR_PARERR = 4;
  localparam int CSR_PARON  = 5;
  localparam int CSR_PSENSE = 6;

  localparam logic ADDR_CSR  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic dataShift;
    logic parCapture;
    logic frameDone;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sampleTick,
  input  logic      rxLine,
  input  logic      rxEnable,
  input  logic      parityOn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             bitEnd;

  assign bitEnd = sampleTick && (tickCnt == LAST_TICK);

  always_comb begin
    strobe.dataShift  = (state == ST_DATA) && bitEnd;
    strobe.parCapture = (state == ST_PAR)  && bitEnd;
    strobe.frameDone  = (state == ST_STOP) && bitEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!rxLine) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == MID_TICK) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_TICK) begin
            tickCnt <= '0;
            if (bitIdx == LAST_BIT) state <= parityOn ? ST_PAR : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (tickCnt == LAST_TICK) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST_TICK) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  rxStrobe_t        strobe,
  input  logic             busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  output logic [REG_W-1:0] statusWord,
  output logic [REG_W-1:0] dataWord,
  output logic             rxEnable,
  output logic             parityOn
);
  logic [DATA_BITS-1:0] shifter;
  logic [DATA_BITS-1:0] dataReg;
  logic parBit, paritySense;
  logic fullFlag, parErr, ovrErr, frmErr;
  logic csrWrite, dataRead, enableRise;
  logic accept, overrun, parityBad, stopBad;

  assign csrWrite   = busWrEn && (busAddr == ADDR_CSR);
  assign dataRead   = busRdEn && (busAddr == ADDR_DATA);
  assign enableRise = csrWrite && busWrData[CSR_RXEN] && !rxEnable;

  assign accept    = strobe.frameDone && !fullFlag;
  assign overrun   = strobe.frameDone && fullFlag;
  assign stopBad   = !rxLine;
  assign parityBad = parityOn && ((^{shifter, parBit}) ^ ~paritySense);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shifter <= '0;
      parBit  <= 1'b0;
    end else begin
      if (strobe.dataShift)  shifter <= {rxLine, shifter[DATA_BITS-1:1]};
      if (strobe.parCapture) parBit  <= rxLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataReg     <= '0;
      fullFlag    <= 1'b0;
      rxEnable    <= 1'b0;
      parityOn    <= 1'b0;
      paritySense <= 1'b0;
      parErr      <= 1'b0;
      ovrErr      <= 1'b0;
      frmErr      <= 1'b0;
    end else begin
      if (csrWrite) begin
        rxEnable    <= busWrData[CSR_RXEN];
        parityOn    <= busWrData[CSR_PARON];
        paritySense <= busWrData[CSR_PSENSE];
      end

      if (accept) begin
        dataReg  <= shifter;
        fullFlag <= 1'b1;
      end else if (dataRead || enableRise) begin
        fullFlag <= 1'b0;
      end

      if (accept && parityBad) parErr <= 1'b1;
      else if (csrWrite && !busWrData[CSR_PARERR]) parErr <= 1'b0;

      if (overrun) ovrErr <= 1'b1;
      else if (csrWrite && !busWrData[CSR_OVRERR]) ovrErr <= 1'b0;

      if (accept && stopBad) frmErr <= 1'b1;
      else if (csrWrite && !busWrData[CSR_FRMERR]) frmErr <= 1'b0;
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[CSR_RXEN]    = rxEnable;
    statusWord[CSR_FULL]    = fullFlag;
    statusWord[CSR_FRMERR]  = frmErr;
    statusWord[CSR_OVRERR]  = ovrErr;
    statusWord[CSR_PARERR]  = parErr;
    statusWord[CSR_PARON]   = parityOn;
    statusWord[CSR_PSENSE]  = paritySense;
    dataWord                = '0;
    dataWord[DATA_BITS-1:0] = dataReg;
    busRdData = (busAddr == ADDR_DATA) ? dataWord : statusWord;
  end
endmodule

// File: rtl/uart_rx_csr.sv
module uart_rx_csr
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxLine,
  input  logic       sampleTick,
  input  logic       busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData
);
  rxStrobe_t        strobe;
  logic [REG_W-1:0] statusWord;
  logic [REG_W-1:0] dataWord;
  logic             rxEnable;
  logic             parityOn;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) ctrl (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .parityOn(parityOn), .strobe(strobe)
  );

  uart_rx_dpath #(.DATA_BITS(DATA_BITS)) dpath (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .strobe(strobe),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .statusWord(statusWord), .dataWord(dataWord),
    .rxEnable(rxEnable), .parityOn(parityOn)
  );
endmodule

// File: rtl/uart_rx_csr_chk.sv
module uart_rx_csr_chk
  import uart_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busAddr,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [REG_W-1:0] busWrData,
  input rxStrobe_t        strobe,
  input logic [REG_W-1:0] statusWord,
  input logic [REG_W-1:0] dataWord
);
  logic csrWr;
  assign csrWr = busWrEn && (busAddr == ADDR_CSR);

  // R3
  full_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == ADDR_DATA && !strobe.frameDone) |=> !statusWord[CSR_FULL]);

  // R9
  full_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusWord[CSR_FULL]) |-> $past(strobe.frameDone));

  // R7
  data_hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dataWord) |-> $past(!statusWord[CSR_FULL]));

  // R8
  par_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[CSR_PARERR] && !(csrWr && !busWrData[CSR_PARERR])) |=> statusWord[CSR_PARERR]);

  // R8
  ovr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[CSR_OVRERR] && !(csrWr && !busWrData[CSR_OVRERR])) |=> statusWord[CSR_OVRERR]);

  // R8
  frm_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[CSR_FRMERR] && !(csrWr && !busWrData[CSR_FRMERR])) |=> statusWord[CSR_FRMERR]);

  // R10
  no_frame_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWord[CSR_RXEN] |=> !strobe.frameDone);
endmodule

bind uart_rx_csr uart_rx_csr_chk chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busWrData(busWrData), .strobe(strobe),
  .statusWord(statusWord), .dataWord(dataWord)
);

// File: tb/uart_rx_csr_test.sv
module uart_rx_csr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleTick = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  // expected model
  bit       eEn, eFull, ePar, eOvr, eFrm, ePon, ePs;
  bit [7:0] eData;

  uart_rx_csr uut (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .sampleTick(sampleTick),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  initial forever #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    sampleTick = ~sampleTick;
  end

  function automatic bit parFor(input bit [7:0] d, input bit even);
    return even ? (^d) : ~(^d);
  endfunction

  function automatic bit [7:0] expCsr();
    return {1'b0, ePs, ePon, ePar, eOvr, eFrm, eFull, eEn};
  endfunction

  task automatic check(input string req, input bit [7:0] act, input bit [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * 2) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    rxLine = b;
    waitTicks(16);
  endtask

  task automatic sendFrame(input bit [7:0] d, input bit pOn, input bit pEven,
                           input bit flipPar, input bit badStop);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    if (pOn) sendBit(parFor(d, pEven) ^ flipPar);
    if (badStop) begin
      rxLine = 1'b0;
      waitTicks(10);
      rxLine = 1'b1;
      waitTicks(26);
    end else begin
      sendBit(1'b1);
      waitTicks(20);
    end
  endtask

  task automatic writeReg(input bit a, input bit [7:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input bit a, input bit strobeRd, output bit [7:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = strobeRd;
    #1 v = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic writeCsrModel();
    writeReg(1'b0, {1'b0, ePs, ePon, ePar, eOvr, eFrm, 1'b0, eEn});
  endtask

  // model of a frame arriving while enabled
  task automatic modelFrame(input bit [7:0] d, input bit flipPar, input bit badStop);
    if (eFull) eOvr = 1'b1;
    else begin
      eData = d; eFull = 1'b1;
      if (ePon && flipPar) ePar = 1'b1;
      if (badStop) eFrm = 1'b1;
    end
  endtask

  initial begin
    bit [7:0] v;
    bit [7:0] d;
    bit pOn, pEv;
    int seed;
    seed = $urandom(32'h1d5e);
    eEn = 0; eFull = 0; ePar = 0; eOvr = 0; eFrm = 0; ePon = 0; ePs = 0; eData = 0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    readReg(1'b0, 1'b0, v); check("R1 csr", v, 8'h00);
    readReg(1'b1, 1'b0, v); check("R1 data", v, 8'h00);

    // R10: disabled receiver ignores a frame
    sendFrame(8'h5a, 1'b0, 1'b0, 1'b0, 1'b0);
    readReg(1'b0, 1'b0, v); check("R10 csr", v, 8'h00);
    readReg(1'b1, 1'b0, v); check("R10 data", v, 8'h00);

    eEn = 1; writeCsrModel();

    // R2/R3/R4/R5: random frames with random parity configuration
    for (int k = 0; k < 10; k++) begin
      d = 8'($urandom);
      pOn = 1'($urandom); pEv = 1'($urandom);
      ePon = pOn; ePs = pEv; writeCsrModel();
      sendFrame(d, pOn, pEv, 1'b0, 1'b0);
      modelFrame(d, 1'b0, 1'b0);
      readReg(1'b0, 1'b0, v); check(pOn ? "R2 R4 csr" : "R2 R5 csr", v, expCsr());
      readReg(1'b1, 1'b1, v); check("R2 data", v, eData);
      eFull = 0;
      readReg(1'b0, 1'b0, v); check("R3 full cleared", v, expCsr());
    end

    // R4: parity mismatch, both senses
    for (int s = 0; s < 2; s++) begin
      ePon = 1; ePs = 1'(s); writeCsrModel();
      d = (s == 0) ? 8'hc3 : 8'h17;
      sendFrame(d, 1'b1, ePs, 1'b1, 1'b0);
      modelFrame(d, 1'b1, 1'b0);
      readReg(1'b0, 1'b0, v); check("R4 par err", v, expCsr());
      readReg(1'b1, 1'b1, v); check("R4 data kept", v, d);
      eFull = 0;
      // R8: writing 1 keeps flag, writing 0 clears
      writeReg(1'b0, {1'b0, ePs, ePon, 1'b1, 3'b000, eEn});
      readReg(1'b0, 1'b0, v); check("R8 keep par", v, expCsr());
      ePar = 0; writeCsrModel();
      readReg(1'b0, 1'b0, v); check("R8 clear par", v, expCsr());
    end

    // R5: parity off, odd-weight data, no parity error
    ePon = 0; ePs = 1; writeCsrModel();
    sendFrame(8'h07, 1'b0, 1'b0, 1'b0, 1'b0);
    modelFrame(8'h07, 1'b0, 1'b0);
    readReg(1'b0, 1'b0, v); check("R5 no par err", v, expCsr());
    readReg(1'b1, 1'b1, v); check("R5 data", v, 8'h07);
    eFull = 0;

    // R6: framing error
    sendFrame(8'ha6, 1'b0, 1'b0, 1'b0, 1'b1);
    modelFrame(8'ha6, 1'b0, 1'b1);
    readReg(1'b0, 1'b0, v); check("R6 frm err", v, expCsr());
    readReg(1'b1, 1'b1, v); check("R6 data", v, 8'ha6);
    eFull = 0;
    writeReg(1'b0, {1'b0, ePs, ePon, 3'b111, 1'b0, eEn});
    readReg(1'b0, 1'b0, v); check("R8 keep frm", v, expCsr());
    eFrm = 0; writeCsrModel();
    readReg(1'b0, 1'b0, v); check("R8 clear frm", v, expCsr());

    // R7: overrun keeps old data
    sendFrame(8'h3c, 1'b0, 1'b0, 1'b0, 1'b0); modelFrame(8'h3c, 1'b0, 1'b0);
    sendFrame(8'hc9, 1'b0, 1'b0, 1'b0, 1'b0); modelFrame(8'hc9, 1'b0, 1'b0);
    readReg(1'b0, 1'b0, v); check("R7 ovr err", v, expCsr());
    readReg(1'b1, 1'b0, v); check("R7 old data", v, 8'h3c);

    // R12: data register write ignored
    writeReg(1'b1, 8'h81);
    readReg(1'b1, 1'b0, v); check("R12 data unchanged", v, 8'h3c);

    // R9: csr write of 0 in full bit does not clear it (enable stays 1)
    writeCsrModel();
    readReg(1'b0, 1'b0, v); check("R9 full not writable", v, expCsr());
    // R9: enable 0 -> 1 clears full
    eEn = 0; writeCsrModel();
    readReg(1'b0, 1'b0, v); check("R9 full kept when off", v, expCsr());
    eEn = 1; eFull = 0; writeCsrModel();
    readReg(1'b0, 1'b0, v); check("R9 full cleared by enable", v, expCsr());
    eOvr = 0; writeCsrModel();
    readReg(1'b0, 1'b0, v); check("R8 clear ovr", v, expCsr());

    // R11: start glitch rejected
    rxLine = 1'b0; waitTicks(3); rxLine = 1'b1; waitTicks(30);
    readReg(1'b0, 1'b0, v); check("R11 glitch no char", v, expCsr());
    sendFrame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0); modelFrame(8'h96, 1'b0, 1'b0);
    readReg(1'b0, 1'b0, v); check("R11 csr after glitch", v, expCsr());
    readReg(1'b1, 1'b1, v); check("R11 data after glitch", v, 8'h96);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule